// File: doc/BRIEF.md
# Peripheral Bus Glue with Write-Controlled Reset Latch

This block sits between a microcontroller bus with a 16-bit address and separate active-low read and write strobes, and an 8-bit memory-mapped communications controller. It decodes the controller's chip select from the latched address. It also tells the processor to treat the whole peripheral region as an 8-bit bus.

The controller's reset line is not a register bit. A byte write anywhere in one 256-byte page pulls the reset line low. A byte write anywhere in the next page releases it. Every access that starts in the peripheral region is stretched by a fixed number of wait states, so the slow controller has time to respond.

After system reset the controller is held in reset until software performs its first release write.

Top module: `pbus_glue`

## Requirements
- R1: `dev_sel_n` is low exactly when `addr` lies in 0xCA00..0xCAFF. It is decoded from the address alone, with no register in the path.
- R2: `bus8` is high exactly when `addr` lies in 0xCA00..0xCCFF. It is combinational.
- R3: After system reset, `dev_rst_n` is low and stays low until a release write occurs.
- R4: A byte write (`wr_n` low and `byte_acc` high, sampled at a rising clock edge) to 0xCB00..0xCBFF makes `dev_rst_n` low from that edge on.
- R5: A byte write to 0xCC00..0xCCFF makes `dev_rst_n` high from that edge on.
- R6: The following leave `dev_rst_n` unchanged:
  - word writes (`byte_acc` low) to either reset page;
  - reads of either reset page;
  - any access outside the two reset pages.
- R7: When a strobe first goes active with `addr` in 0xCA00..0xCCFF, `wait_req` is high in that same cycle. It stays high for exactly three further clock cycles and is then low, even if the strobe is still held. A new wait sequence starts only after both strobes have been inactive for at least one clock edge.
- R8: An access outside 0xCA00..0xCCFF never raises `wait_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high system reset |
| addr | input | 16 | Latched bus address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| byte_acc | input | 1 | High for an 8-bit access, low for a 16-bit access |
| dev_sel_n | output | 1 | Active-low chip select to the controller |
| dev_rst_n | output | 1 | Active-low reset to the controller |
| bus8 | output | 1 | Forces 8-bit bus width for the peripheral region |
| wait_req | output | 1 | High while the processor must stretch the access |

## Verification
The assertions assume the following about the inputs:
- `addr` and `byte_acc` stay stable while a strobe is active.
- The read and write strobes are never active together.
- Each access that should start a fresh wait sequence is preceded by a cycle with both strobes inactive.

The stimulus meets these assumptions by changing inputs only on the falling clock edge. Every task sets the address and the access flag at the moment it asserts a strobe. After each access the strobes are released and several idle cycles follow before the next scenario starts.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

    localparam int AW = 16;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_SEL,
        RG_HOLD,
        RG_RUN
    } region_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic byte_x;
    } strobe_t;

    function automatic logic in_win(input logic [AW-1:0] a,
                                    input logic [AW-1:0] base,
                                    input int unsigned   span);
        logic [AW-1:0] top_a;
        top_a = base + AW'(span - 1);
        return (a >= base) && (a <= top_a);
    endfunction

    function automatic region_e classify(input logic [AW-1:0] a,
                                         input logic [AW-1:0] sel_b,
                                         input logic [AW-1:0] hold_b,
                                         input logic [AW-1:0] run_b,
                                         input int unsigned   span);
        if (in_win(a, sel_b, span))       return RG_SEL;
        else if (in_win(a, hold_b, span)) return RG_HOLD;
        else if (in_win(a, run_b, span))  return RG_RUN;
        else                              return RG_NONE;
    endfunction

endpackage

// File: rtl/pbg_decode.sv
module pbg_decode
    import pbg_pkg::*;
#(
    parameter logic [AW-1:0] SEL_BASE  = 16'hCA00,
    parameter logic [AW-1:0] HOLD_BASE = 16'hCB00,
    parameter logic [AW-1:0] RUN_BASE  = 16'hCC00,
    parameter int unsigned   WIN_BITS  = 8
) (
    input  logic [AW-1:0] addr,
    output region_e       region,
    output logic          sel_n,
    output logic          wide8
);
    localparam int unsigned SPAN = 1 << WIN_BITS;

    always_comb begin
        region = classify(addr, SEL_BASE, HOLD_BASE, RUN_BASE, SPAN);
        sel_n  = (region != RG_SEL);
        wide8  = (region != RG_NONE);
    end
endmodule

// File: rtl/pbg_rst_latch.sv
module pbg_rst_latch
    import pbg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  region_e region,
    input  strobe_t stb,
    output logic    dev_rst_n
);
    logic held_q;
    logic hold_wr;
    logic run_wr;

    always_comb begin
        hold_wr = stb.wr && stb.byte_x && (region == RG_HOLD);
        run_wr  = stb.wr && stb.byte_x && (region == RG_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst)          held_q <= 1'b1;
        else if (hold_wr) held_q <= 1'b1;
        else if (run_wr)  held_q <= 1'b0;
    end

    assign dev_rst_n = ~held_q;

    // R3
    held_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dev_rst_n);
    // R4
    hold_write_chk: assert property (@(posedge clk) disable iff (rst)
        hold_wr |=> !dev_rst_n);
    // R5
    run_write_chk: assert property (@(posedge clk) disable iff (rst)
        run_wr |=> dev_rst_n);
    // R6
    no_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(hold_wr || run_wr) |=> $stable(dev_rst_n));
endmodule

// File: rtl/pbg_wait_gen.sv
module pbg_wait_gen #(
    parameter int unsigned WAIT_STATES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic access,
    input  logic in_reg,
    output logic wait_o
);
    localparam int unsigned CW = $clog2(WAIT_STATES + 1);

    logic          act_q;
    logic [CW-1:0] cnt;
    logic          start;

    always_comb begin
        start  = access && in_reg && !act_q && (cnt == '0);
        wait_o = start || (cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt   <= '0;
        end else begin
            act_q <= access;
            if (start)           cnt <= CW'(WAIT_STATES);
            else if (cnt != '0)  cnt <= cnt - CW'(1);
        end
    end

    // R7
    wait_stay_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> wait_o);
    // R7
    wait_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(1) && access) |=> !wait_o);
    // R8
    wait_outside_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_reg && cnt == '0) |-> !wait_o);
endmodule

// File: rtl/pbus_glue.sv
module pbus_glue
    import pbg_pkg::*;
#(
    parameter logic [15:0] SEL_BASE    = 16'hCA00,
    parameter logic [15:0] HOLD_BASE   = 16'hCB00,
    parameter logic [15:0] RUN_BASE    = 16'hCC00,
    parameter int unsigned WIN_BITS    = 8,
    parameter int unsigned WAIT_STATES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        byte_acc,
    output logic        dev_sel_n,
    output logic        dev_rst_n,
    output logic        bus8,
    output logic        wait_req
);
    region_e region;
    strobe_t stb;

    always_comb begin
        stb.rd     = ~rd_n;
        stb.wr     = ~wr_n;
        stb.byte_x = byte_acc;
    end

    pbg_decode #(
        .SEL_BASE (SEL_BASE),
        .HOLD_BASE(HOLD_BASE),
        .RUN_BASE (RUN_BASE),
        .WIN_BITS (WIN_BITS)
    ) u_dec (
        .addr  (addr),
        .region(region),
        .sel_n (dev_sel_n),
        .wide8 (bus8)
    );

    pbg_rst_latch u_rl (
        .clk      (clk),
        .rst      (rst),
        .region   (region),
        .stb      (stb),
        .dev_rst_n(dev_rst_n)
    );

    pbg_wait_gen #(.WAIT_STATES(WAIT_STATES)) u_wg (
        .clk   (clk),
        .rst   (rst),
        .access(stb.rd || stb.wr),
        .in_reg(bus8),
        .wait_o(wait_req)
    );

    // R1 R2
    sel_in_wide_chk: assert property (@(posedge clk) disable iff (rst)
        !dev_sel_n |-> bus8);
endmodule

// File: tb/pbus_glue_tb.sv
module pbus_glue_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        byte_acc = 1'b0;
    logic        dev_sel_n, dev_rst_n, bus8, wait_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pbus_glue u_dut (
        .clk(clk), .rst(rst), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .byte_acc(byte_acc), .dev_sel_n(dev_sel_n), .dev_rst_n(dev_rst_n),
        .bus8(bus8), .wait_req(wait_req)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    task automatic idle(input int n);
        addr = 16'h0000; rd_n = 1'b1; wr_n = 1'b1; byte_acc = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R3 reset dev_rst_n", dev_rst_n, 1'b0);
        check("R8 reset wait_req", wait_req, 1'b0);
        check("R1 reset sel", dev_sel_n, 1'b1);
    endtask

    task automatic decode_one(input logic [15:0] a, input logic exp_sel_n, input logic exp_b8);
        @(negedge clk);
        addr = a; #1;
        check("R1 chip select", dev_sel_n, exp_sel_n);
        check("R2 bus8", bus8, exp_b8);
    endtask

    task automatic t_decode();
        decode_one(16'hC9FF, 1'b1, 1'b0);
        decode_one(16'hCA00, 1'b0, 1'b1);
        decode_one(16'hCAFF, 1'b0, 1'b1);
        decode_one(16'hCB00, 1'b1, 1'b1);
        decode_one(16'hCCFF, 1'b1, 1'b1);
        decode_one(16'hCD00, 1'b1, 1'b0);
        decode_one(16'h1234, 1'b1, 1'b0);
        idle(1);
    endtask

    // one-cycle write (or read) then check the reset line after the edge
    task automatic t_access(input string req, input logic [15:0] a, input logic is_wr,
                            input logic is_byte, input logic exp_rst_n);
        @(negedge clk);
        addr = a; byte_acc = is_byte;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1; #1;
        check(req, dev_rst_n, exp_rst_n);
        idle(6);
        check(req, dev_rst_n, exp_rst_n);
    endtask

    task automatic t_wait(input string req, input logic [15:0] a, input logic is_wr,
                          input logic exp_on);
        @(negedge clk);
        addr = a; byte_acc = 1'b0;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        #1;
        check(req, wait_req, exp_on);
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk); #1;
            check(req, wait_req, exp_on && (i <= 3));
        end
        idle(3);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_access("R6 word write release page", 16'hCC00, 1'b1, 1'b0, 1'b0);
        t_access("R6 read release page",       16'hCC10, 1'b0, 1'b1, 1'b0);
        t_access("R5 byte release",            16'hCC40, 1'b1, 1'b1, 1'b1);
        t_access("R6 word write hold page",    16'hCB00, 1'b1, 1'b0, 1'b1);
        t_access("R6 outside byte write",      16'hCA80, 1'b1, 1'b1, 1'b1);
        t_access("R4 byte hold",               16'hCBFF, 1'b1, 1'b1, 1'b0);
        t_access("R5 byte release low edge",   16'hCC00, 1'b1, 1'b1, 1'b1);
        t_wait("R7 read wait",       16'hCA10, 1'b0, 1'b1);
        t_wait("R7 word write wait", 16'hCB20, 1'b1, 1'b1);
        t_wait("R8 outside read",    16'h4000, 1'b0, 1'b0);
        t_wait("R8 just past region",16'hCD00, 1'b1, 1'b0);
        check("R6 after wait tests", dev_rst_n, 1'b1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule